// File: doc/BRIEF.md
# Configurable SPI Byte Transceiver

This block moves one byte at a time over a four-wire SPI link, acting as the clock-generating master or as a slave that follows an external clock. Three control bits shape the timing. A polarity bit sets the idle level of the serial clock. An edge bit sets which clock edge launches new data, and it is inverted against the usual phase numbering: standard mode 0 means the edge bit is 1. A sample bit, used by the master, chooses whether incoming data is captured in the middle of its output window or at its end. Data moves most significant bit first.

Software sees a register-like interface. It writes a byte to transmit, reads the last received byte, and watches four sticky flags: buffer full, write collision, receive overflow and byte complete. The byte-complete flag raises a wake request when its enable is set. In master mode the block divides the system clock into serial-clock half periods. When the module clock gate (`run_en`) is low, a master transfer stops and keeps its exact state, then continues once the gate returns. The slave logic ignores that gate and follows the external clock edges. A low reset, or clearing the enable bit, aborts any transfer and returns the block to idle.

Top module: `spi_xcvr`

## Requirements
- R1: `sck_o` rests at `cfg_cpol` whenever no master transfer runs. With `cfg_edge`=1, each `sdo` bit is stable at the leading edge (the edge leaving the idle level) and changes on the trailing edge. With `cfg_edge`=0, `sdo` changes on the leading edge and is stable at the trailing edge. Bits go out MSB first.
- R2: In master mode, `cfg_smp`=0 captures `sdi` in the middle of the peer's output window and `cfg_smp`=1 captures it at the end. For a peer that changes data on the edge opposite to the sampling edge, both settings return the peer's byte on `rd_data`.
- R3: A write (`wr_en`) while `busy` is high sets `wcol` and changes neither the byte on the wire nor the transfer in progress.
- R4: When a byte completes while `buf_full` is still set and no read happens in that cycle, `ovf` is set and `rd_data` keeps its earlier byte.
- R5: A `rd_en` pulse clears `buf_full`. The flags `wcol`, `ovf` and `irq` stay set until a 1 is written to `flag_clr` bit 0, bit 1 or bit 2 respectively.
- R6: Every completed byte sets `irq`. `wake` is high exactly when `irq` and `irq_en` are both high.
- R7: While `run_en` is low, a master transfer holds `sck_o`, `busy` and its bit position. When `run_en` returns, the transfer completes with correct data.
- R8: In slave mode (`cfg_master`=0), bits are shifted on `sck_i` edges whatever the level of `run_en`. After 8 sampling edges the byte appears on `rd_data` with `buf_full` set.
- R9: In slave mode, `ss_n` high puts `sdo_oe` low and clears the bit count, so a partial byte is dropped and the next selection starts at bit 7.
- R10: After reset, `busy`, `buf_full`, `wcol`, `ovf`, `irq` and `sdo_oe` are 0. Clearing `cfg_en` during a master transfer drops `busy` and returns `sck_o` to `cfg_cpol` on the next clock.
- R11: In master mode, a write while idle starts a transfer, raises `busy`, and makes exactly 16 `sck_o` transitions before `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Module clock gate for the master sequencer |
| cfg_en | input | 1 | Block enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_edge | input | 1 | 1 = data changes on trailing edge, 0 = on leading edge |
| cfg_smp | input | 1 | Master sample point: 0 middle, 1 end |
| irq_en | input | 1 | Enables the wake request |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe; clears buffer full |
| rd_data | output | 8 | Last accepted received byte |
| flag_clr | input | 3 | Clear strobes: bit0 wcol, bit1 ovf, bit2 irq |
| busy | output | 1 | Transfer in progress |
| buf_full | output | 1 | Received byte not yet read |
| wcol | output | 1 | Write collision flag |
| ovf | output | 1 | Receive overflow flag |
| irq | output | 1 | Byte complete flag |
| wake | output | 1 | Wake request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
All eight combinations of polarity, edge and sample bits are run against a peer model that drives and samples on the edges the mode calls for. A design with the edge bit in the conventional sense would hand the peer a byte shifted by one bit. The clock gate is dropped in the middle of a byte. A sequencer that kept counting would toggle `sck_o` or finish early. Writes during a transfer, unread bytes, a slave deselect after three bits, and disabling the block mid-byte are each driven on purpose. A wrong design would corrupt the outgoing byte, overwrite the held byte, misalign the next slave byte, or leave the clock stuck at its active level.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  localparam int DW = 8;
  localparam int NSTEP = 2 * DW + 1;
  localparam int KW = $clog2(NSTEP);
  localparam int CW = $clog2(DW + 1);

  // edge_b = 1: data launched on trailing edge; half-step k counts from 0.
  function automatic logic samp_step(input logic [KW-1:0] k, input logic edge_b, input logic smp);
    if (edge_b)
      samp_step = (k < KW'(2 * DW)) && (k[0] == smp);
    else if (smp)
      samp_step = (k != '0) && !k[0];
    else
      samp_step = k[0];
  endfunction

  function automatic logic shift_step(input logic [KW-1:0] k, input logic edge_b);
    shift_step = edge_b ? k[0] : ((k != '0) && !k[0]);
  endfunction

  function automatic logic toggle_step(input logic [KW-1:0] k);
    toggle_step = (k < KW'(2 * DW));
  endfunction
endpackage

// File: rtl/spi_xcvr_mseq.sv
module spi_xcvr_mseq import spi_xcvr_pkg::*; #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic run_en,
  input  logic start,
  input  logic edge_b,
  input  logic smp,
  output logic busy_o,
  output logic act_o,
  output logic samp_o,
  output logic shift_o,
  output logic done_o
);
  localparam int DCW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DCW-1:0] DIV_LAST = DCW'(DIV_HALF - 1);
  localparam logic [KW-1:0] K_LAST = KW'(2 * DW);

  logic [KW-1:0]  k_q;
  logic [DCW-1:0] div_q;
  logic           busy_q, act_q;
  logic           step;

  assign step = busy_q && run_en && (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q <= '0; div_q <= '0; busy_q <= 1'b0; act_q <= 1'b0;
    end else if (!en) begin
      k_q <= '0; div_q <= '0; busy_q <= 1'b0; act_q <= 1'b0;
    end else if (start && !busy_q) begin
      k_q <= '0; div_q <= '0; busy_q <= 1'b1; act_q <= 1'b0;
    end else if (busy_q && run_en) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (toggle_step(k_q)) act_q <= ~act_q;
        if (k_q == K_LAST) busy_q <= 1'b0;
        else k_q <= k_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign act_o   = act_q;
  assign samp_o  = step && samp_step(k_q, edge_b, smp);
  assign shift_o = step && shift_step(k_q, edge_b);
  assign done_o  = step && (k_q == K_LAST);

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && en && !run_en) |=> (busy_q && $stable(k_q) && $stable(act_q)));
  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !act_q);
  assert_done_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_q);
endmodule

// File: rtl/spi_xcvr_sseq.sv
module spi_xcvr_sseq import spi_xcvr_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cpol,
  input  logic edge_b,
  input  logic sck_i,
  input  logic ss_n,
  output logic active_o,
  output logic samp_o,
  output logic shift_o,
  output logic done_o
);
  localparam logic [CW-1:0] C_LAST = CW'(DW - 1);

  logic [1:0]    sck_s, ss_s;
  logic          sck_d;
  logic [CW-1:0] cnt_q;
  logic          sel, lead, trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0; sck_d <= 1'b0; ss_s <= 2'b11;
    end else begin
      sck_s <= {sck_s[0], sck_i};
      sck_d <= sck_s[1];
      ss_s  <= {ss_s[0], ss_n};
    end
  end

  assign sel   = en && !ss_s[1];
  assign lead  = (sck_s[1] != sck_d) && (sck_s[1] != cpol);
  assign trail = (sck_s[1] != sck_d) && (sck_s[1] == cpol);

  assign samp_o  = sel && (edge_b ? lead : trail);
  assign shift_o = sel && (edge_b ? trail : (lead && (cnt_q != '0)));
  assign done_o  = samp_o && (cnt_q == C_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!sel)     cnt_q <= '0;
    else if (samp_o)   cnt_q <= (cnt_q == C_LAST) ? '0 : cnt_q + 1'b1;
  end

  assign active_o = (cnt_q != '0);

  assert_deselect_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s[1] |=> (cnt_q == '0));
endmodule

// File: rtl/spi_xcvr_stat.sv
module spi_xcvr_stat import spi_xcvr_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_en,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  input  logic          rd_en,
  input  logic [2:0]    flag_clr,
  input  logic          irq_en,
  output logic          load_o,
  output logic [DW-1:0] rx_buf_o,
  output logic          full_o,
  output logic          wcol_o,
  output logic          ovf_o,
  output logic          irq_o,
  output logic          wake_o
);
  logic [DW-1:0] rx_buf_q;
  logic full_q, wcol_q, ovf_q, irq_q;
  logic coll, held, over;

  assign load_o = en && wr_en && !busy;
  assign coll   = en && wr_en && busy;
  assign held   = full_q && !rd_en;
  assign over   = done && held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf_q <= '0; full_q <= 1'b0; wcol_q <= 1'b0; ovf_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (done && !held) begin
        rx_buf_q <= rx_byte;
        full_q   <= 1'b1;
      end else if (rd_en) begin
        full_q <= 1'b0;
      end
      wcol_q <= coll | (wcol_q & ~flag_clr[0]);
      ovf_q  <= over | (ovf_q & ~flag_clr[1]);
      irq_q  <= done | (irq_q & ~flag_clr[2]);
    end
  end

  assign rx_buf_o = rx_buf_q;
  assign full_o   = full_q;
  assign wcol_o   = wcol_q;
  assign ovf_o    = ovf_q;
  assign irq_o    = irq_q;
  assign wake_o   = irq_q && irq_en;

  assert_wcol_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    coll |=> wcol_q);
  assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    over |=> (ovf_q && $stable(rx_buf_q)));
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !done) |=> !full_q);
  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_q);
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr import spi_xcvr_pkg::*; #(
  parameter int DIV_HALF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          cfg_en,
  input  logic          cfg_master,
  input  logic          cfg_cpol,
  input  logic          cfg_edge,
  input  logic          cfg_smp,
  input  logic          irq_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [2:0]    flag_clr,
  output logic          busy,
  output logic          buf_full,
  output logic          wcol,
  output logic          ovf,
  output logic          irq,
  output logic          wake,
  output logic          sck_o,
  input  logic          sck_i,
  input  logic          ss_n,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe
);
  logic m_en, s_en, load, start;
  logic m_busy, m_act, m_samp, m_shift, m_done;
  logic s_act, s_samp, s_shift, s_done;
  logic samp_evt, shift_evt, done_evt;
  logic [DW-1:0] tx_sr, rx_sr, rx_next, rx_done;

  assign m_en = cfg_en && cfg_master;
  assign s_en = cfg_en && !cfg_master;

  spi_xcvr_mseq #(.DIV_HALF(DIV_HALF)) u_mseq (
    .clk(clk), .rst_n(rst_n), .en(m_en), .run_en(run_en), .start(start),
    .edge_b(cfg_edge), .smp(cfg_smp), .busy_o(m_busy), .act_o(m_act),
    .samp_o(m_samp), .shift_o(m_shift), .done_o(m_done));

  spi_xcvr_sseq u_sseq (
    .clk(clk), .rst_n(rst_n), .en(s_en), .cpol(cfg_cpol), .edge_b(cfg_edge),
    .sck_i(sck_i), .ss_n(ss_n), .active_o(s_act), .samp_o(s_samp),
    .shift_o(s_shift), .done_o(s_done));

  assign samp_evt  = m_samp | s_samp;
  assign shift_evt = m_shift | s_shift;
  assign done_evt  = m_done | s_done;
  assign busy      = cfg_master ? m_busy : s_act;
  assign start     = load && cfg_master;
  assign rx_next   = {rx_sr[DW-2:0], sdi};
  assign rx_done   = samp_evt ? rx_next : rx_sr;

  spi_xcvr_stat u_stat (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .wr_en(wr_en), .busy(busy),
    .done(done_evt), .rx_byte(rx_done), .rd_en(rd_en), .flag_clr(flag_clr),
    .irq_en(irq_en), .load_o(load), .rx_buf_o(rd_data), .full_o(buf_full),
    .wcol_o(wcol), .ovf_o(ovf), .irq_o(irq), .wake_o(wake));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0; rx_sr <= '0;
    end else begin
      if (load)           tx_sr <= wr_data;
      else if (shift_evt) tx_sr <= {tx_sr[DW-2:0], 1'b0};
      if (samp_evt)       rx_sr <= rx_next;
    end
  end

  assign sdo    = tx_sr[DW-1];
  assign sdo_oe = cfg_en && (cfg_master || !ss_n);
  assign sck_o  = cfg_cpol ^ (m_act && cfg_master);

  assert_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sdo == $past(wr_data[DW-1])));
  assert_one_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_done && s_done));
endmodule

// File: tb/spi_xcvr_tb.sv
`timescale 1ns/1ps
module spi_xcvr_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, run_en, cfg_en, cfg_master, cfg_cpol, cfg_edge, cfg_smp, irq_en;
  logic wr_en, rd_en, sl_sck, ss_n, sdi, sl_sdi, use_model, model_clr;
  logic [7:0] wr_data, rd_data, pat, cap;
  logic [2:0] flag_clr;
  logic busy, buf_full, wcol, ovf, irq, wake, sck_o, sdo, sdo_oe;
  int checks = 0, errors = 0;
  int pidx, capn, lead_seen;
  logic sck_prev, lead;

  spi_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_en(cfg_en), .cfg_master(cfg_master),
    .cfg_cpol(cfg_cpol), .cfg_edge(cfg_edge), .cfg_smp(cfg_smp), .irq_en(irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .flag_clr(flag_clr), .busy(busy), .buf_full(buf_full), .wcol(wcol), .ovf(ovf),
    .irq(irq), .wake(wake), .sck_o(sck_o), .sck_i(sl_sck), .ss_n(ss_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe));

  // peer model for master tests: drives pat MSB first, captures sdo on its sample edge
  assign sdi = use_model ? ((pidx < 8) ? pat[3'(7 - pidx)] : 1'b0) : sl_sdi;

  always @(negedge clk) begin
    if (model_clr) begin
      pidx = 0; capn = 0; cap = '0; lead_seen = 0; sck_prev = cfg_cpol;
    end else if (sck_o !== sck_prev) begin
      lead = (sck_o !== cfg_cpol);
      if (lead) lead_seen++;
      if (cfg_edge ? lead : !lead) begin cap = {cap[6:0], sdo}; capn++; end
      if (cfg_edge ? !lead : (lead && lead_seen > 1)) pidx++;
      sck_prev = sck_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_master(input logic [2:0] md, input logic [7:0] tx, input logic [7:0] p);
    @(negedge clk);
    cfg_master = 1'b1; use_model = 1'b1; {cfg_cpol, cfg_edge, cfg_smp} = md; pat = p; model_clr = 1'b1;
    cyc(2);
    model_clr = 1'b0; wr_data = tx; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic clr(input logic [2:0] m);
    flag_clr = m; @(negedge clk); flag_clr = '0;
  endtask

  task automatic sl_toggle();
    sl_sck = ~sl_sck; cyc(8);
  endtask

  // slave byte: rxb goes into the design, txe is expected on sdo
  task automatic slave_byte(input logic [7:0] rxb, input logic [7:0] txe);
    for (int i = 7; i >= 0; i--) begin
      sl_sdi = rxb[i];
      if (cfg_edge) begin
        chk("R1 slave sdo bit", sdo, txe[i]);
        sl_toggle(); sl_toggle();
      end else begin
        sl_toggle();
        chk("R1 slave sdo bit", sdo, txe[i]);
        sl_toggle();
      end
    end
  endtask

  // {cpol, edge, smp, tx byte, peer byte}
  localparam logic [18:0] VEC [8] = '{
    {3'b010, 8'hA5, 8'h3C}, {3'b011, 8'h81, 8'h7E},
    {3'b000, 8'h5A, 8'hC3}, {3'b001, 8'hF0, 8'h0F},
    {3'b110, 8'h12, 8'hED}, {3'b111, 8'h96, 8'h69},
    {3'b100, 8'h01, 8'h80}, {3'b101, 8'hCE, 8'h31}};

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic s_sck;
    logic [7:0] s_rd;
    rst_n = 0; run_en = 1; cfg_en = 0; cfg_master = 1; cfg_cpol = 0; cfg_edge = 1; cfg_smp = 0;
    irq_en = 0; wr_en = 0; rd_en = 0; wr_data = '0; flag_clr = '0; sl_sck = 0; ss_n = 1;
    sl_sdi = 0; use_model = 1; model_clr = 1; pat = '0;
    cyc(4);
    // R10 reset state
    chk("R10 busy", busy, 0); chk("R10 buf_full", buf_full, 0); chk("R10 wcol", wcol, 0);
    chk("R10 ovf", ovf, 0); chk("R10 irq", irq, 0); chk("R10 sdo_oe", sdo_oe, 0);
    rst_n = 1; cfg_en = 1; cyc(2);

    // R1 R2 R11 table walk over all mode combinations
    for (int v = 0; v < 8; v++) begin
      start_master(VEC[v][18:16], VEC[v][15:8], VEC[v][7:0]);
      chk("R11 busy after write", busy, 1);
      wait_idle();
      chk("R2 received byte", rd_data, VEC[v][7:0]);
      chk("R1 peer saw tx byte", cap, VEC[v][15:8]);
      chk("R11 sck transitions", lead_seen * 2, 16);
      chk("R1 sck idle level", sck_o, VEC[v][18]);
      chk("R6 irq set", irq, 1);
      chk("R5 buf_full set", buf_full, 1);
      do_read();
      chk("R5 read clears full", buf_full, 0);
      clr(3'b100);
      chk("R5 irq cleared", irq, 0);
    end

    // R3 write collision
    start_master(3'b010, 8'hA5, 8'h11);
    cyc(10);
    wr_data = 8'h3C; wr_en = 1; @(negedge clk); wr_en = 0;
    chk("R3 wcol set", wcol, 1);
    wait_idle();
    chk("R3 tx unchanged", cap, 8'hA5);
    cyc(5);
    chk("R5 wcol sticky", wcol, 1);
    clr(3'b001);
    chk("R5 wcol cleared", wcol, 0);

    // R6 wake
    irq_en = 1; @(negedge clk);
    chk("R6 wake on", wake, 1);
    irq_en = 0; @(negedge clk);
    chk("R6 wake off", wake, 0);

    // R4 overflow: buffer holds 0x11 unread
    start_master(3'b010, 8'h00, 8'h22);
    wait_idle();
    chk("R4 ovf set", ovf, 1);
    chk("R4 buffer kept", rd_data, 8'h11);
    cyc(3);
    chk("R5 ovf sticky", ovf, 1);
    clr(3'b010);
    chk("R5 ovf cleared", ovf, 0);
    do_read(); clr(3'b100);

    // R7 clock gate freeze
    start_master(3'b110, 8'h6B, 8'hD4);
    cyc(25);
    run_en = 0; @(negedge clk);
    s_sck = sck_o;
    cyc(60);
    chk("R7 busy held", busy, 1);
    chk("R7 sck held", sck_o, s_sck);
    run_en = 1;
    wait_idle();
    chk("R7 rx after resume", rd_data, 8'hD4);
    chk("R7 tx after resume", cap, 8'h6B);
    do_read(); clr(3'b100);

    // R10 disable aborts
    start_master(3'b100, 8'hFF, 8'h00);
    cyc(21);
    cfg_en = 0; @(negedge clk);
    chk("R10 abort busy", busy, 0);
    chk("R10 abort sck idle", sck_o, 1);
    chk("R10 no byte", buf_full, 0);
    cfg_en = 1; cyc(2);

    // R8 slave, clock gate off
    use_model = 0; cfg_master = 0; cfg_cpol = 0; cfg_edge = 1; sl_sck = 0; run_en = 0;
    cyc(4);
    chk("R9 oe off deselected", sdo_oe, 0);
    wr_data = 8'hC9; wr_en = 1; @(negedge clk); wr_en = 0;
    ss_n = 0; cyc(4);
    chk("R9 oe on selected", sdo_oe, 1);
    slave_byte(8'h5E, 8'hC9);
    chk("R8 slave rx", rd_data, 8'h5E);
    chk("R8 slave full", buf_full, 1);
    chk("R6 slave irq", irq, 1);
    ss_n = 1; cyc(4);
    do_read(); clr(3'b100);
    run_en = 1;

    // R9 partial byte dropped on deselect
    cfg_cpol = 1; cfg_edge = 0; sl_sck = 1; cyc(4);
    ss_n = 0; cyc(4);
    for (int i = 0; i < 6; i++) begin sl_sdi = i[0]; sl_toggle(); end
    ss_n = 1; cyc(6);
    chk("R9 no partial byte", buf_full, 0);
    chk("R9 busy cleared", busy, 0);
    wr_data = 8'h3A; wr_en = 1; @(negedge clk); wr_en = 0;
    ss_n = 0; cyc(4);
    slave_byte(8'hB7, 8'h3A);
    s_rd = rd_data;
    chk("R9 aligned byte", s_rd, 8'hB7);
    ss_n = 1; cyc(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule